// File: doc/BRIEF.md
# Compact-Jet Window Scanner

This block looks for jet candidates in a captured grid of calorimeter tower transverse energies. One board holds a 12 (eta) by 4 (phi) patch of towers. Two extra phi columns from each neighbouring board are delivered alongside that patch, so the block sees a 12 by 8 grid. A 4 by 4 window steps across this grid one tower at a time. For each window the block reports the summed ET and a compactness figure, n60. n60 is how many of the window's largest towers, taken in descending order, are needed before their sum reaches 60% of the window total. Narrow, well-contained jets give a small n60. Diffuse pileup gives a large one.

A `start` pulse captures the grid and the ring-mode setting. The block then scans every window position, one per clock, and reports each result on the candidate port. A window counts as a candidate (`cand_emit`) only when two conditions hold: its ET is strictly above the jet threshold, and its compactness flag is set. The flag is set when n60 is below a programmable cut, which resets to 7. Isolation, sorting and merging happen downstream.

Top module: `jet_window_finder`

## Requirements
- R1: After reset, `cand_valid` and `cand_emit` are 0 and remain 0 until a scan produces results.
- R2: In open mode, window anchors take eta 0..8 and phi 0..4, which gives 45 results per scan. They are reported in raster order with eta changing fastest. `cand_eta`/`cand_phi` give the window's lowest eta and lowest phi tower.
- R3: The tower at eta e and phi column p occupies `grid_et[(p*12+e)*8 +: 8]`, as an unsigned value. Columns 0-1 and 6-7 are the neighbour columns.
- R4: `cand_et` equals the sum of the 16 towers in the window: eta anchor..anchor+3 and phi anchor..anchor+3.
- R5: For a window with nonzero total T, `cand_n60` is the smallest k (1..16) for which the k largest towers sum to S with 10*S >= 6*T. An exact 60% share counts as reached.
- R6: A window whose total is 0 reports `cand_n60` = 16 and `cand_flag` = 0.
- R7: For nonzero windows, `cand_flag` is 1 exactly when `cand_n60` is less than the cut register. The cut register resets to 7 and takes `cut_val` on a clock edge where `cut_we` is 1.
- R8: `cand_emit` is 1 exactly when `cand_valid` is 1, `cand_flag` is 1, and `cand_et` > `jet_thresh`.
- R9: When `wrap_en` is 1 at start, the 8 columns form a full ring. Phi anchors run 0..7, and column indices wrap modulo 8, so 72 results are produced. Eta never wraps in either mode.
- R10: `grid_et` and `wrap_en` are sampled only on the start edge. A `start` that arrives during a scan is ignored, and so are grid changes during a scan.
- R11: If `start` is sampled at edge 0, the first result appears after edge 3. Results then follow on consecutive cycles, and `cand_valid` drops after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture grid and mode, begin a scan |
| wrap_en | input | 1 | Treat the 8 phi columns as a closed ring |
| grid_et | input | 768 | Tower ET grid, 96 towers of 8 bits |
| jet_thresh | input | 12 | Candidate ET threshold (strictly exceeded) |
| cut_we | input | 1 | Write enable for the n60 cut register |
| cut_val | input | 5 | New n60 cut value |
| cand_valid | output | 1 | A window result is present |
| cand_emit | output | 1 | The window qualifies as a jet candidate |
| cand_eta | output | 4 | Window eta anchor |
| cand_phi | output | 3 | Window phi anchor |
| cand_et | output | 12 | Window ET sum |
| cand_n60 | output | 5 | Compactness count |
| cand_flag | output | 1 | Compactness flag |

## Verification
The bench uses several grids, and each one isolates a different part of the function:

- An all-zero grid exercises the empty-window convention.
- A single hot tower gives n60 = 1 wherever it is covered. Run against thresholds one apart, it also pins the strict comparison.
- A 60/40 tower pair lands exactly on the 60% boundary, which separates `>=` from `>`.
- A uniform grid has a large total but n60 = 10. It shows that the sum alone never qualifies a window, until the cut is raised.
- Random backgrounds with hot spots, run in open and ring modes, test the raster order, the phi wrap, and the rule that a mid-scan start is ignored.

// File: rtl/jf_pkg.sv
package jf_pkg;
    localparam int ETA_N     = 12;
    localparam int PHI_CORE  = 4;
    localparam int HALO      = 2;
    localparam int WIN       = 4;
    localparam int ET_W      = 8;
    localparam int CUT_RESET = 7;

    localparam int PHI_EXT       = PHI_CORE + 2 * HALO;
    localparam int CELLS         = WIN * WIN;
    localparam int SUM_W         = ET_W + $clog2(CELLS);
    localparam int N60_W         = $clog2(CELLS + 1);
    localparam int ETA_W         = $clog2(ETA_N);
    localparam int PHI_W         = $clog2(PHI_EXT);
    localparam int GRID_W        = ETA_N * PHI_EXT * ET_W;
    localparam int CMP_W         = SUM_W + 4;
    localparam int ETA_LAST      = ETA_N - WIN;
    localparam int PHI_LAST_OPEN = PHI_EXT - WIN;
    localparam int PHI_LAST_RING = PHI_EXT - 1;

    typedef logic [CELLS-1:0][ET_W-1:0] cells_t;

    typedef struct packed {
        logic             valid;
        logic [ETA_W-1:0] eta;
        logic [PHI_W-1:0] phi;
        cells_t           cells;
        logic [SUM_W-1:0] total;
    } win_t;
endpackage

// File: rtl/jf_scan_ctrl.sv
module jf_scan_ctrl
    import jf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wrap_en,
    output logic             busy,
    output logic             wrap,
    output logic [ETA_W-1:0] eta,
    output logic [PHI_W-1:0] phi,
    output logic             capture
);
    typedef struct packed {
        logic             busy;
        logic             wrap;
        logic [ETA_W-1:0] eta;
        logic [PHI_W-1:0] phi;
    } scan_t;

    scan_t            st_d, st_q;
    logic [PHI_W-1:0] phi_last;

    always_comb begin
        st_d     = st_q;
        phi_last = st_q.wrap ? PHI_W'(PHI_LAST_RING) : PHI_W'(PHI_LAST_OPEN);
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.wrap = wrap_en;
                st_d.eta  = '0;
                st_d.phi  = '0;
            end
        end else if (st_q.eta == ETA_W'(ETA_LAST)) begin
            st_d.eta = '0;
            if (st_q.phi == phi_last) st_d.busy = 1'b0;
            else                      st_d.phi  = st_q.phi + 1'b1;
        end else begin
            st_d.eta = st_q.eta + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign wrap    = st_q.wrap;
    assign eta     = st_q.eta;
    assign phi     = st_q.phi;
    assign capture = start && !st_q.busy;

    assert_scan_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.eta == '0 && st_q.phi == '0));

    assert_eta_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.eta <= ETA_W'(ETA_LAST));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start) |=> $stable(st_q.wrap));
endmodule

// File: rtl/jf_window_sel.sv
module jf_window_sel
    import jf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [GRID_W-1:0] grid_in,
    input  logic              busy,
    input  logic              wrap,
    input  logic [ETA_W-1:0]  eta,
    input  logic [PHI_W-1:0]  phi,
    output win_t              win_o
);
    typedef struct packed {
        logic [GRID_W-1:0] grid;
        win_t              s1;
    } sel_t;

    sel_t            st_d, st_q;
    int              col_c, row_c;
    logic [ET_W-1:0] cell_c;

    always_comb begin
        st_d          = st_q;
        col_c         = 0;
        row_c         = 0;
        cell_c        = '0;
        if (capture) st_d.grid = grid_in;
        st_d.s1.valid = busy;
        st_d.s1.eta   = eta;
        st_d.s1.phi   = phi;
        st_d.s1.total = '0;
        for (int j = 0; j < WIN; j++) begin
            for (int i = 0; i < WIN; i++) begin
                col_c = int'(phi) + j;
                if (wrap && col_c >= PHI_EXT) col_c = col_c - PHI_EXT;
                row_c  = int'(eta) + i;
                cell_c = st_q.grid[(col_c * ETA_N + row_c) * ET_W +: ET_W];
                st_d.s1.cells[j * WIN + i] = cell_c;
                st_d.s1.total = st_d.s1.total + SUM_W'(cell_c);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_o = st_q.s1;

    assert_window_eta_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1.valid |-> st_q.s1.eta <= ETA_W'(ETA_LAST));
endmodule

// File: rtl/jf_n60_eval.sv
module jf_n60_eval
    import jf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  win_t             win_i,
    input  logic [SUM_W-1:0] thresh,
    input  logic [N60_W-1:0] cut,
    output logic             o_valid,
    output logic             o_emit,
    output logic [ETA_W-1:0] o_eta,
    output logic [PHI_W-1:0] o_phi,
    output logic [SUM_W-1:0] o_et,
    output logic [N60_W-1:0] o_n60,
    output logic             o_flag
);
    typedef struct packed {
        logic             valid;
        logic [ETA_W-1:0] eta;
        logic [PHI_W-1:0] phi;
        cells_t           sorted;
        logic [SUM_W-1:0] total;
    } srt_t;

    typedef struct packed {
        logic             valid;
        logic             emit;
        logic [ETA_W-1:0] eta;
        logic [PHI_W-1:0] phi;
        logic [SUM_W-1:0] et;
        logic [N60_W-1:0] n60;
        logic             flag;
    } res_t;

    typedef struct packed {
        srt_t s2;
        res_t o;
    } eval_t;

    eval_t            st_d, st_q;
    logic [ET_W-1:0]  arr_c [CELLS];
    logic [ET_W-1:0]  tmp_c;
    logic [SUM_W-1:0] pre_c;
    logic             found_c;

    always_comb begin
        st_d = st_q;
        // stage 2: odd-even transposition network, descending
        for (int k = 0; k < CELLS; k++) arr_c[k] = win_i.cells[k];
        tmp_c = '0;
        for (int s = 0; s < CELLS; s++) begin
            for (int i = s % 2; i < CELLS - 1; i += 2) begin
                if (arr_c[i] < arr_c[i+1]) begin
                    tmp_c      = arr_c[i];
                    arr_c[i]   = arr_c[i+1];
                    arr_c[i+1] = tmp_c;
                end
            end
        end
        st_d.s2.valid = win_i.valid;
        st_d.s2.eta   = win_i.eta;
        st_d.s2.phi   = win_i.phi;
        st_d.s2.total = win_i.total;
        for (int k = 0; k < CELLS; k++) st_d.s2.sorted[k] = arr_c[k];

        // stage 3: prefix sum against 60 percent of the total
        pre_c      = '0;
        found_c    = 1'b0;
        st_d.o.n60 = N60_W'(CELLS);
        for (int k = 0; k < CELLS; k++) begin
            pre_c = pre_c + SUM_W'(st_q.s2.sorted[k]);
            if (!found_c && (({4'd0, pre_c} * CMP_W'(10)) >= ({4'd0, st_q.s2.total} * CMP_W'(6)))) begin
                found_c    = 1'b1;
                st_d.o.n60 = N60_W'(k + 1);
            end
        end
        if (st_q.s2.total == '0) begin
            st_d.o.n60  = N60_W'(CELLS);
            st_d.o.flag = 1'b0;
        end else begin
            st_d.o.flag = (st_d.o.n60 < cut);
        end
        st_d.o.valid = st_q.s2.valid;
        st_d.o.eta   = st_q.s2.eta;
        st_d.o.phi   = st_q.s2.phi;
        st_d.o.et    = st_q.s2.total;
        st_d.o.emit  = st_q.s2.valid && st_d.o.flag && (st_q.s2.total > thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_valid = st_q.o.valid;
    assign o_emit  = st_q.o.emit;
    assign o_eta   = st_q.o.eta;
    assign o_phi   = st_q.o.phi;
    assign o_et    = st_q.o.et;
    assign o_n60   = st_q.o.n60;
    assign o_flag  = st_q.o.flag;

    assert_sort_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2.valid |-> st_q.s2.sorted[0] >= st_q.s2.sorted[CELLS-1]);

    assert_n60_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.o.valid && st_q.o.et != '0) |-> (st_q.o.n60 >= 1 && st_q.o.n60 <= N60_W'(CELLS)));

    assert_empty_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.o.valid && st_q.o.et == '0) |-> (st_q.o.n60 == N60_W'(CELLS) && !st_q.o.flag));

    assert_emit_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.o.emit |-> (st_q.o.valid && st_q.o.flag));
endmodule

// File: rtl/jet_window_finder.sv
module jet_window_finder
    import jf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wrap_en,
    input  logic [GRID_W-1:0] grid_et,
    input  logic [SUM_W-1:0]  jet_thresh,
    input  logic              cut_we,
    input  logic [N60_W-1:0]  cut_val,
    output logic              cand_valid,
    output logic              cand_emit,
    output logic [ETA_W-1:0]  cand_eta,
    output logic [PHI_W-1:0]  cand_phi,
    output logic [SUM_W-1:0]  cand_et,
    output logic [N60_W-1:0]  cand_n60,
    output logic              cand_flag
);
    logic [N60_W-1:0] cut_d, cut_q;
    logic             busy_w, wrap_w, cap_w;
    logic [ETA_W-1:0] eta_w;
    logic [PHI_W-1:0] phi_w;
    win_t             win_w;

    always_comb begin
        cut_d = cut_q;
        if (cut_we) cut_d = cut_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cut_q <= N60_W'(CUT_RESET);
        else        cut_q <= cut_d;
    end

    jf_scan_ctrl u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wrap_en (wrap_en),
        .busy    (busy_w),
        .wrap    (wrap_w),
        .eta     (eta_w),
        .phi     (phi_w),
        .capture (cap_w)
    );

    jf_window_sel u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_w),
        .grid_in (grid_et),
        .busy    (busy_w),
        .wrap    (wrap_w),
        .eta     (eta_w),
        .phi     (phi_w),
        .win_o   (win_w)
    );

    jf_n60_eval u_eval (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_i   (win_w),
        .thresh  (jet_thresh),
        .cut     (cut_q),
        .o_valid (cand_valid),
        .o_emit  (cand_emit),
        .o_eta   (cand_eta),
        .o_phi   (cand_phi),
        .o_et    (cand_et),
        .o_n60   (cand_n60),
        .o_flag  (cand_flag)
    );

    assert_emit_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cand_emit |-> cand_valid);

    assert_results_follow_scan_R11: assert property (@(posedge clk) disable iff (!rst_n)
        win_w.valid |=> ##1 cand_valid);
endmodule

// File: tb/jet_window_finder_tb_top.sv
module jet_window_finder_tb_top;
    import jf_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              wrap_en = 1'b0;
    logic [GRID_W-1:0] grid_et = '0;
    logic [SUM_W-1:0]  jet_thresh = '0;
    logic              cut_we = 1'b0;
    logic [N60_W-1:0]  cut_val = '0;
    logic              cand_valid, cand_emit, cand_flag;
    logic [ETA_W-1:0]  cand_eta;
    logic [PHI_W-1:0]  cand_phi;
    logic [SUM_W-1:0]  cand_et;
    logic [N60_W-1:0]  cand_n60;

    always #4 clk = ~clk;

    jet_window_finder dut_i (.*);

    typedef struct { int eta; int phi; int et; int n60; int flag; int emit; } exp_t;
    exp_t        sb_q[$];
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R3: tower (e,p) lives at bits (p*12+e)*8 +: 8
    task automatic set_tower(input int e, input int p, input int v);
        grid_et[(p * ETA_N + e) * ET_W +: ET_W] = ET_W'(v);
    endtask

    function automatic int tower(input int e, input int p);
        return int'(grid_et[(p * ETA_N + e) * ET_W +: ET_W]);
    endfunction

    function automatic int rnd(input int m);
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'((seed >> 8) % m);
    endfunction

    task automatic model_push(input bit wrap, input int thr, input int cut, output int nwin);
        int np;
        np   = wrap ? PHI_EXT : PHI_EXT - WIN + 1;
        nwin = 0;
        for (int p = 0; p < np; p++) begin
            for (int e = 0; e <= ETA_N - WIN; e++) begin
                int v[16];
                int tot, pre, n60, t;
                exp_t x;
                tot = 0;
                for (int j = 0; j < WIN; j++)
                    for (int i = 0; i < WIN; i++) begin
                        v[j*WIN+i] = tower(e + i, (p + j) % PHI_EXT);
                        tot += v[j*WIN+i];
                    end
                for (int a = 0; a < 16; a++)
                    for (int b = a + 1; b < 16; b++)
                        if (v[b] > v[a]) begin t = v[a]; v[a] = v[b]; v[b] = t; end
                n60 = 16; pre = 0;
                if (tot != 0)
                    for (int k = 0; k < 16; k++) begin
                        pre += v[k];
                        if (10 * pre >= 6 * tot) begin n60 = k + 1; break; end
                    end
                x.eta  = e; x.phi = p; x.et = tot; x.n60 = n60;
                x.flag = (tot != 0 && n60 < cut) ? 1 : 0;
                x.emit = (x.flag == 1 && tot > thr) ? 1 : 0;
                sb_q.push_back(x);
                nwin++;
            end
        end
    endtask

    // Monitor: pop one expectation per reported window
    always @(negedge clk) begin
        if (rst_n && cand_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 unexpected window", 1, 0);
            end else begin
                exp_t x;
                x = sb_q.pop_front();
                chk(int'(cand_eta) == x.eta && int'(cand_phi) == x.phi,
                    "R2 R9 position eta*8+phi", int'(cand_eta) * 8 + int'(cand_phi), x.eta * 8 + x.phi);
                chk(int'(cand_et) == x.et, "R3 R4 window ET", int'(cand_et), x.et);
                chk(int'(cand_n60) == x.n60, "R5/R6 n60", int'(cand_n60), x.n60);
                chk(int'(cand_flag) == x.flag, "R6/R7 flag", int'(cand_flag), x.flag);
                chk(int'(cand_emit) == x.emit, "R8 emit", int'(cand_emit), x.emit);
            end
        end
    end

    task automatic run_scan(input bit wrap, input int cut, input bit inject);
        int nwin;
        model_push(wrap, int'(jet_thresh), cut, nwin);
        @(negedge clk); start = 1'b1; wrap_en = wrap;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        for (int k = 1; k <= nwin + 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (inject && k == 5) begin
                start = 1'b1; wrap_en = ~wrap;       // R10: ignored mid-scan
                for (int b = 0; b < GRID_W / 8; b++) grid_et[b*8 +: 8] = 8'hFF;
            end
            if (inject && k == 6) start = 1'b0;
            if (k == 2)        chk(cand_valid == 1'b0, "R11 no result before edge 3", int'(cand_valid), 0);
            if (k == 3)        chk(cand_valid == 1'b1, "R11 first result after edge 3", int'(cand_valid), 1);
            if (k == nwin + 2) chk(cand_valid == 1'b1, "R11 last result contiguous", int'(cand_valid), 1);
            if (k == nwin + 3) begin
                chk(cand_valid == 1'b0, "R11 valid drops after scan", int'(cand_valid), 0);
                chk(sb_q.size() == 0, "R2 R10 all windows consumed", sb_q.size(), 0);
            end
        end
    endtask

    task automatic write_cut(input int v);
        @(negedge clk); cut_we = 1'b1; cut_val = N60_W'(v);
        @(negedge clk); cut_we = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cand_valid == 1'b0 && cand_emit == 1'b0, "R1 reset outputs", int'(cand_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cand_valid == 1'b0, "R1 idle after reset", int'(cand_valid), 0);

        // R6: empty grid
        grid_et = '0; jet_thresh = '0;
        run_scan(1'b0, 7, 1'b0);

        // R8: single hot tower, threshold equal then one below
        grid_et = '0; set_tower(5, 3, 100); jet_thresh = 12'd100;
        run_scan(1'b0, 7, 1'b0);
        jet_thresh = 12'd99;
        run_scan(1'b0, 7, 1'b0);

        // R5: exact 60 percent share
        grid_et = '0; set_tower(4, 2, 60); set_tower(6, 4, 40); jet_thresh = 12'd50;
        run_scan(1'b0, 7, 1'b0);

        // R7: uniform grid, n60 = 10, rejected at reset cut, accepted at cut 11
        for (int p = 0; p < PHI_EXT; p++) for (int e = 0; e < ETA_N; e++) set_tower(e, p, 10);
        run_scan(1'b0, 7, 1'b0);
        write_cut(11);
        run_scan(1'b0, 11, 1'b0);
        write_cut(7);

        // R10: random background with hot spots, mid-scan start
        for (int p = 0; p < PHI_EXT; p++) for (int e = 0; e < ETA_N; e++) set_tower(e, p, rnd(12));
        set_tower(2, 1, 220); set_tower(9, 5, 180); set_tower(10, 5, 90);
        jet_thresh = 12'd150;
        run_scan(1'b0, 7, 1'b1);

        // R9: ring mode with hot spots across the phi seam
        for (int p = 0; p < PHI_EXT; p++) for (int e = 0; e < ETA_N; e++) set_tower(e, p, rnd(10));
        set_tower(3, 7, 200); set_tower(3, 0, 150); set_tower(11, 6, 230); set_tower(0, 1, 170);
        run_scan(1'b1, 7, 1'b0);

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R2 scoreboard empty at end", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule